// File: doc/BRIEF.md
# Two-Level Nanoprogrammed Control Store

This block is the controller of a small accumulator machine. It is built as two table lookups in a row. A 32-entry micro-store holds the sequencing fields of every micro-step: a 2-bit branch condition, a 1-bit choice of jump source, a 5-bit jump target and a 4-bit pattern index. The pattern index is not decoded by fixed logic. It selects one row of a 16-entry nano-store, and that row is the 12-bit control word driven to the datapath. Both tables are parameters, so new microcode or new control patterns can be loaded without touching any logic.

The sequencer behaves like a one-level microsequencer. It increments the micro-address, or it loads the micro-address either from the word's jump target or from the opcode on the bus. The nano-store output is registered, so the control lines for a micro-address appear one cycle after that address is shown on `uaddr`. The sequencer therefore always runs one stage ahead of the control lines. Its branch inputs (`bus_op`, `zero_flag`) are sampled in the cycle the branching word is addressed.

The default tables hold a short program. It has a fetch and dispatch sequence, plus routines for load, add, subtract, store, jump-if-zero, clear and halt. Only 13 distinct control patterns are needed, and index 0 is the idle pattern.

Top module: `nano_ctrl_store`

## Requirements
- R1: While `rst_n` is low (asynchronous, active low), `uaddr` is 0 and `ctrl` is all zero.
- R2: A micro-word whose condition field is 0 (or 3) makes the next `uaddr` equal to the current `uaddr` plus one, modulo 32.
- R3: A micro-word with condition 1 and jump source 0 makes the next `uaddr` equal to its 5-bit jump target.
- R4: A micro-word with condition 1 and jump source 1 makes the next `uaddr` equal to `bus_op`, zero-extended to 5 bits.
- R5: A micro-word with condition 2 jumps to its target when `zero_flag` is 1, and increments when `zero_flag` is 0.
- R6: `ctrl` in cycle t+1 is the nano-store row selected by the pattern index of the micro-word addressed by `uaddr` in cycle t.
- R7: Nano index 0 drives all control lines low. With the default tables, the control bits are numbered 0 pc_out, 1 pc_inc, 2 pc_load, 3 const_out, 4 acc_out, 5 acc_load, 6 tmp_load, 7 alu_sub, 8 mar_load, 9 mem_out, 10 mem_write, 11 halt. The address shown one cycle earlier then drives the following bits:
  - address 8: {0,8}
  - address 9: {1,9}
  - addresses 10 and 29: {3,6}
  - addresses 11, 15, 19, 22 and 25: {0,1,8}
  - addresses 12, 16, 20 and 23: {8,9}
  - addresses 13 and 17: {5,9}
  - addresses 14 and 18: {4,6}
  - address 21: {5,7,9}
  - address 24: {4,10}
  - address 28: {2,9}
  - address 30: {3,5}
  - address 31: {11}
  - every other address: no bits
- R8: With the default micro-store, the following sequencing holds:
  - addresses 0 to 7 jump to 8, 10, 14, 18, 22, 25, 29 and 31 respectively;
  - address 9 jumps to `bus_op`;
  - address 26 goes to 28 if `zero_flag` is 1, else to 27;
  - addresses 13, 17, 21, 24, 27, 28, 30 and 31 return to 8;
  - all other addresses increment.
- R9: `bus_op` has no effect on `uaddr` or `ctrl` except at a word with condition 1 and jump source 1. `zero_flag` has no effect except at a word with condition 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_op | input | OPW (3) | Opcode currently on the bus |
| zero_flag | input | 1 | Accumulator-is-zero status |
| ctrl | output | CW (12) | Registered control lines from the nano-store |
| uaddr | output | AW (5) | Current micro-address |

## Verification
The bench builds the block with its default parameters: a 5-bit micro-address, a 3-bit opcode, a 4-bit nano index, 12 control lines, and the default micro-store and nano-store. This setting lets the opcode dispatch reach every routine, and the two runs of jump-if-zero cover both arms of the conditional branch, so every one of the 32 micro-addresses is visited. At each visited address, the two-level output one cycle later is compared with a horizontal control word the bench holds for that address. During these runs, the opcode and zero inputs are deliberately wrong everywhere except at the single words that may sample them.

// File: rtl/nano_ctrl_store.sv
module nano_ctrl_store #(
  parameter int AW  = 5,
  parameter int OPW = 3,
  parameter int NW  = 4,
  parameter int CW  = 12,
  parameter logic [3+AW+NW-1:0] USTORE [2**AW] = '{
    {2'd1, 1'b0, 5'd8,  4'd0},
    {2'd1, 1'b0, 5'd10, 4'd0},
    {2'd1, 1'b0, 5'd14, 4'd0},
    {2'd1, 1'b0, 5'd18, 4'd0},
    {2'd1, 1'b0, 5'd22, 4'd0},
    {2'd1, 1'b0, 5'd25, 4'd0},
    {2'd1, 1'b0, 5'd29, 4'd0},
    {2'd1, 1'b0, 5'd31, 4'd0},
    {2'd0, 1'b0, 5'd0,  4'd1},
    {2'd1, 1'b1, 5'd0,  4'd2},
    {2'd0, 1'b0, 5'd0,  4'd3},
    {2'd0, 1'b0, 5'd0,  4'd4},
    {2'd0, 1'b0, 5'd0,  4'd5},
    {2'd1, 1'b0, 5'd8,  4'd6},
    {2'd0, 1'b0, 5'd0,  4'd7},
    {2'd0, 1'b0, 5'd0,  4'd4},
    {2'd0, 1'b0, 5'd0,  4'd5},
    {2'd1, 1'b0, 5'd8,  4'd6},
    {2'd0, 1'b0, 5'd0,  4'd7},
    {2'd0, 1'b0, 5'd0,  4'd4},
    {2'd0, 1'b0, 5'd0,  4'd5},
    {2'd1, 1'b0, 5'd8,  4'd8},
    {2'd0, 1'b0, 5'd0,  4'd4},
    {2'd0, 1'b0, 5'd0,  4'd5},
    {2'd1, 1'b0, 5'd8,  4'd9},
    {2'd0, 1'b0, 5'd0,  4'd4},
    {2'd2, 1'b0, 5'd28, 4'd0},
    {2'd1, 1'b0, 5'd8,  4'd0},
    {2'd1, 1'b0, 5'd8,  4'd10},
    {2'd0, 1'b0, 5'd0,  4'd3},
    {2'd1, 1'b0, 5'd8,  4'd11},
    {2'd1, 1'b0, 5'd8,  4'd12}
  },
  parameter logic [CW-1:0] NSTORE [2**NW] = '{
    12'h000, 12'h101, 12'h202, 12'h048,
    12'h103, 12'h300, 12'h220, 12'h050,
    12'h2A0, 12'h410, 12'h204, 12'h028,
    12'h800, 12'h000, 12'h000, 12'h000
  }
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] bus_op,
  input  logic           zero_flag,
  output logic [CW-1:0]  ctrl,
  output logic [AW-1:0]  uaddr
);
  localparam int UW = 3 + AW + NW;

  logic [AW-1:0] upc;
  logic [AW-1:0] upc_nxt;
  logic [UW-1:0] uword;
  logic [1:0]    cond;
  logic          from_bus;
  logic [AW-1:0] target;
  logic [NW-1:0] nidx;
  logic          take;

  assign uword = USTORE[upc];
  assign {cond, from_bus, target, nidx} = uword;

  always_comb begin
    case (cond)
      2'd1:    take = 1'b1;
      2'd2:    take = zero_flag;
      default: take = 1'b0;
    endcase
  end

  assign upc_nxt = take ? (from_bus ? AW'(bus_op) : target) : upc + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upc  <= '0;
      ctrl <= '0;
    end else begin
      upc  <= upc_nxt;
      ctrl <= NSTORE[nidx];
    end
  end

  assign uaddr = upc;

  // R2
  seq_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 2'd0 || cond == 2'd3) |=> uaddr == AW'($past(uaddr) + 1'b1));

  // R3
  seq_jump_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 2'd1 && !from_bus) |=> uaddr == $past(target));

  // R4
  seq_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 2'd1 && from_bus) |=> uaddr == AW'($past(bus_op)));

  // R5
  seq_cond_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cond == 2'd2 && !zero_flag) |=> uaddr == AW'($past(uaddr) + 1'b1));

  // R7
  idle_pattern_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nidx == '0) |=> ctrl == '0);
endmodule

// File: tb/tb_nano_ctrl_store.sv
module tb_nano_ctrl_store;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic [4:0]  a;
    logic [11:0] c;
    string       tag;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  bus_op = 3'd0;
  logic        zero_flag = 1'b0;
  logic [11:0] ctrl;
  logic [4:0]  uaddr;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  exp_t q[$];
  exp_t e;
  int cur;
  logic [31:0] visited = '0;

  nano_ctrl_store dut (
    .clk(clk), .rst_n(rst_n), .bus_op(bus_op), .zero_flag(zero_flag),
    .ctrl(ctrl), .uaddr(uaddr)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] href(int a);
    case (a)
      8:                  return 12'h101;
      9:                  return 12'h202;
      10, 29:             return 12'h048;
      11, 15, 19, 22, 25: return 12'h103;
      12, 16, 20, 23:     return 12'h300;
      13, 17:             return 12'h220;
      14, 18:             return 12'h050;
      21:                 return 12'h2A0;
      24:                 return 12'h410;
      28:                 return 12'h204;
      30:                 return 12'h028;
      31:                 return 12'h800;
      default:            return 12'h000;
    endcase
  endfunction

  function automatic int model(int a, logic [2:0] op, logic z);
    case (a)
      0: return 8;
      1: return 10;
      2: return 14;
      3: return 18;
      4: return 22;
      5: return 25;
      6: return 29;
      7: return 31;
      9: return int'(op);
      26: return z ? 28 : 27;
      13, 17, 21, 24, 27, 28, 30, 31: return 8;
      default: return (a + 1) % 32;
    endcase
  endfunction

  task automatic check(string tag, logic [11:0] act, logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic apply(logic [2:0] op, logic z, string tag);
    int nxt;
    bus_op = op;
    zero_flag = z;
    nxt = model(cur, op, z);
    q.push_back('{a: 5'(nxt), c: href(cur), tag: tag});
    visited[cur] = 1'b1;
    cur = nxt;
  endtask

  task automatic step(logic [2:0] op, logic z, string tag);
    @(negedge clk);
    #1;
    apply(op, z, tag);
  endtask

  task automatic run_routine(logic [2:0] op, logic zf, string tag);
    do begin
      if (cur == 9)       step(op, ~zf, {tag, " R4 R8"});
      else if (cur == 26) step(op ^ 3'b101, zf, {tag, " R5 R8"});
      else                step(op ^ 3'b101, ~zf, {tag, " R2 R3 R8 R9"});
    end while (cur != 8);
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      check({e.tag, " uaddr"}, 12'(uaddr), 12'(e.a));
      check({e.tag, " ctrl R6 R7"}, ctrl, e.c);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset uaddr", 12'(uaddr), 12'd0);
    check("R1 reset ctrl", ctrl, 12'd0);
    @(negedge clk);
    #1;
    rst_n = 1'b1;
    cur = 0;
    apply(3'd2, 1'b1, "R3 R8 first step");
    run_routine(3'd1, 1'b0, "lda");
    run_routine(3'd2, 1'b1, "add");
    run_routine(3'd3, 1'b0, "sub");
    run_routine(3'd4, 1'b1, "sta");
    run_routine(3'd5, 1'b1, "jpz taken");
    run_routine(3'd5, 1'b0, "jpz not taken");
    run_routine(3'd6, 1'b1, "clr");
    run_routine(3'd7, 1'b0, "hlt");
    run_routine(3'd0, 1'b1, "nop");
    run_routine(3'd3, 1'b1, "sub again");
    @(negedge clk);
    #2;
    check("R7 all addresses visited", 12'(q.size()), 12'd0);
    checks++;
    if (visited !== 32'hFFFF_FFFF) begin
      fails++;
      $display("FAIL R7 coverage actual=%0h expected=ffffffff", visited);
    end
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset uaddr", 12'(uaddr), 12'd0);
    check("R1 mid-run reset ctrl", ctrl, 12'd0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule